// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Pair

This block is a small glue-logic unit made of two programmable three-input lookup tables, an even table and an odd table, that share one sequential element. Every table input picks its signal from a common pool of sources:

- external pin lines;
- event strobes;
- peripheral lines;
- a feedback copy of the unit output.

Each table evaluates any Boolean function of its three selected inputs through an 8-bit truth table.

Each table result can pass through three conditioning stages, each enabled on its own:

- a two-stage synchronizer;
- a glitch filter that needs four clocks of a steady value;
- a rising-edge pulse detector.

The two conditioned results then drive a shared sequential element. That element works as a JK flip-flop, an RS latch, a D latch or an enable-gated D flip-flop. It can also be bypassed, in which case the even table result is passed straight to the unit output.

Configuration arrives on plain level ports that are held static by the surrounding logic. Latch modes are modelled as transparent paths around a state register clocked by the system clock, so the block contains no real latch or combinational loop.

Top module: `lut_pair_cell`

## Requirements
- R1: Each table input has a 3-bit source code. Codes 0 to 3 select pin_in[0..3], codes 4 and 5 select evt_in[0..1], code 6 selects per_in[0] and code 7 selects the feedback signal. Table t, input i uses cfg_sel[(3*t+i)*3 +: 3]. Unselected sources have no effect.
- R2: With all conditioning off, lut_q[t] equals bit {in2,in1,in0} of cfg_truth[8*t +: 8] in the same cycle, with in0 as the least significant index bit.
- R3: With cfg_sync[t] set, a change of the table result appears on lut_q[t] after exactly two rising clock edges.
- R4: With cfg_filt[t] set, the filtered value takes a new level on the edge that samples that level for the fourth consecutive time. A pulse held for fewer than four edges never reaches lut_q[t].
- R5: With cfg_edge[t] set, a rising conditioned value gives lut_q[t]=1 until the next clock edge and 0 after it. lut_q[t] is never high in two consecutive cycles.
- R6: cfg_mode=0 (bypass) makes unit_out equal lut_q[0] combinationally.
- R7: cfg_mode=1 (JK flip-flop; J=lut_q[0], K=lut_q[1]) behaves as follows on each clock edge. J alone sets unit_out to 1, K alone clears it, J and K together toggle it, and neither holds it.
- R8: cfg_mode=2 (RS latch; S=lut_q[0], R=lut_q[1]) behaves as follows. S forces unit_out to 1 at once, R forces it to 0 at once and wins when both are high, and with both low the last value is held.
- R9: cfg_mode=3 (D latch; D=lut_q[0], enable=lut_q[1]) behaves as follows. While the enable is high, unit_out follows D in the same cycle; while it is low, the value present as the enable fell is held.
- R10: cfg_mode=4 (gated D flip-flop; D=lut_q[0], enable=lut_q[1]) behaves as follows. unit_out takes D on a clock edge where the enable is high and holds otherwise; it never changes between edges.
- R11: The feedback source (code 7) is unit_out delayed by one clock.
- R12: While rst_n is low, the sequential state, the feedback register, the synchronizer, the filter and the edge history are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPIN (4) | External pin lines |
| evt_in | input | NEVT (2) | Event strobes |
| per_in | input | NPER (1) | Peripheral lines |
| cfg_sel | input | 6*SELW (18) | Source codes, three per table |
| cfg_truth | input | 16 | Truth tables, even table in bits 7:0 |
| cfg_sync | input | 2 | Synchronizer enable per table |
| cfg_filt | input | 2 | Filter enable per table |
| cfg_edge | input | 2 | Edge detector enable per table |
| cfg_mode | input | 3 | Sequential mode: 0 bypass, 1 JK, 2 RS, 3 D latch, 4 gated D |
| lut_q | output | 2 | Conditioned table results |
| unit_out | output | 1 | Unit output |

## Verification
Some results are due in the same cycle as their stimulus: the table outputs, bypass, the RS latch and the D latch. For these the bench changes inputs a quarter period after a rising edge and samples one time unit later. Every other result is due a fixed number of rising edges later: the synchronizer after two, the filter after four, the JK and gated D flip-flops and the feedback path after one, and the edge pulse clears after one. For these the bench waits exactly that many edges and samples a quarter period past the last one. It also samples one edge short of each deadline, so that a result arriving early or late is reported.

// File: rtl/lut_pair_cell.sv
module lut_pair_cell #(
  parameter int NPIN = 4,
  parameter int NEVT = 2,
  parameter int NPER = 1,
  parameter int FILT_LEN = 4,
  localparam int NSRC = NPIN + NEVT + NPER + 1,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPIN-1:0]     pin_in,
  input  logic [NEVT-1:0]     evt_in,
  input  logic [NPER-1:0]     per_in,
  input  logic [6*SELW-1:0]   cfg_sel,
  input  logic [15:0]         cfg_truth,
  input  logic [1:0]          cfg_sync,
  input  logic [1:0]          cfg_filt,
  input  logic [1:0]          cfg_edge,
  input  logic [2:0]          cfg_mode,
  output logic [1:0]          lut_q,
  output logic                unit_out
);
  localparam int NSPAN = 1 << SELW;
  localparam logic [2:0] M_JK = 3'd1, M_RS = 3'd2, M_DL = 3'd3, M_GD = 3'd4;

  logic             fb_q;
  logic [NSPAN-1:0] srcx;
  assign srcx = NSPAN'({fb_q, per_in, evt_in, pin_in});

  for (genvar t = 0; t < 2; t++) begin : g_lut
    logic [SELW-1:0]     s0, s1, s2;
    logic [7:0]          tt;
    logic [2:0]          idx;
    logic                raw, s_out, f_out, fval, fprev;
    logic [1:0]          sy;
    logic [FILT_LEN-2:0] hist;
    logic [FILT_LEN-1:0] nh;

    assign s0 = cfg_sel[(3*t+0)*SELW +: SELW];
    assign s1 = cfg_sel[(3*t+1)*SELW +: SELW];
    assign s2 = cfg_sel[(3*t+2)*SELW +: SELW];
    assign tt = cfg_truth[8*t +: 8];
    assign idx = {srcx[s2], srcx[s1], srcx[s0]};
    assign raw = tt[idx];

    assign s_out = cfg_sync[t] ? sy[1] : raw;
    assign nh = {hist, s_out};
    assign f_out = cfg_filt[t] ? fval : s_out;
    assign lut_q[t] = cfg_edge[t] ? (f_out & ~fprev) : f_out;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy    <= '0;
        hist  <= '0;
        fval  <= 1'b0;
        fprev <= 1'b0;
      end else begin
        sy    <= {sy[0], raw};
        hist  <= nh[FILT_LEN-2:0];
        fprev <= f_out;
        if (&nh)       fval <= 1'b1;
        else if (~|nh) fval <= 1'b0;
      end
    end
  end

  logic a, b, q_reg, q_next, seq_o;
  assign a = lut_q[0];
  assign b = lut_q[1];

  always_comb begin
    q_next = q_reg;
    seq_o  = a;
    case (cfg_mode)
      M_JK: begin
        seq_o = q_reg;
        if (a && !b)      q_next = 1'b1;
        else if (!a && b) q_next = 1'b0;
        else if (a && b)  q_next = ~q_reg;
      end
      M_RS: begin
        seq_o  = b ? 1'b0 : (a ? 1'b1 : q_reg);
        q_next = seq_o;
      end
      M_DL: begin
        seq_o  = b ? a : q_reg;
        q_next = seq_o;
      end
      M_GD: begin
        seq_o  = q_reg;
        q_next = b ? a : q_reg;
      end
      default: ;
    endcase
  end

  assign unit_out = seq_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_reg <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      q_reg <= q_next;
      fb_q  <= seq_o;
    end
  end
endmodule

// File: rtl/lut_pair_chk.sv
module lut_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_edge,
  input logic [2:0] cfg_mode,
  input logic [1:0] lut_q,
  input logic       unit_out
);
  // R6
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0) |-> (unit_out == lut_q[0]));

  // R7
  jk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd1 && lut_q[0] && !lut_q[1]) |=> (cfg_mode != 3'd1 || unit_out));

  // R8
  rs_reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd2 && lut_q[1]) |-> !unit_out);

  // R9
  dlatch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd3 && lut_q[1]) |-> (unit_out == lut_q[0]));

  // R10
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd4 && !lut_q[1]) |=> (cfg_mode != 3'd4 || $stable(unit_out)));

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_edge[0] |-> !(lut_q[0] && $past(lut_q[0])));
endmodule

bind lut_pair_cell lut_pair_chk u_chk (.*);

// File: tb/sim_lut_pair_cell.sv
module sim_lut_pair_cell;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] pin_in = '0;
  logic [1:0] evt_in = '0;
  logic [0:0] per_in = '0;
  logic [17:0] cfg_sel = '0;
  logic [15:0] cfg_truth = '0;
  logic [1:0] cfg_sync = '0, cfg_filt = '0, cfg_edge = '0;
  logic [2:0] cfg_mode = '0;
  logic [1:0] lut_q;
  logic unit_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lut_pair_cell u0 (.*);

  // {truth[7:0], pins[2:0], expected}
  localparam logic [11:0] VEC [10] = '{
    {8'h80, 3'd7, 1'b1}, {8'h80, 3'd6, 1'b0}, {8'hFE, 3'd0, 1'b0},
    {8'hFE, 3'd4, 1'b1}, {8'h96, 3'd1, 1'b1}, {8'h96, 3'd3, 1'b0},
    {8'hE8, 3'd5, 1'b1}, {8'hE8, 3'd4, 1'b0}, {8'h01, 3'd0, 1'b1},
    {8'h7F, 3'd7, 1'b0}};

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic settle();
    #1;
  endtask

  function automatic logic [17:0] sels(logic [2:0] a0, a1, a2, b0, b1, b2);
    return {b2, b1, b0, a2, a1, a0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic seq_setup(logic [2:0] mode);
    cfg_sel = sels(3'd0, 3'd2, 3'd2, 3'd1, 3'd2, 3'd2);
    cfg_truth = 16'hAAAA;
    cfg_sync = '0; cfg_filt = '0; cfg_edge = '0;
    cfg_mode = mode;
    pin_in = '0;
    do_reset();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_sel = sels(3'd0, 3'd1, 3'd2, 3'd4, 3'd6, 3'd3);
    cfg_truth = 16'hAAAA;
    cfg_mode = 3'd1;
    pin_in = 4'b0011;
    rst_n = 1'b0;
    tick(3);
    // R12: reset holds sequential state at 0 even with J asserted
    chk("R12 unit_out in reset", unit_out, 1'b0);
    rst_n = 1'b1;
    cfg_mode = 3'd0;
    settle();

    // R2, R6: vector table
    for (int k = 0; k < 10; k++) begin
      cfg_truth[7:0] = VEC[k][11:4];
      pin_in[2:0] = VEC[k][3:1];
      settle();
      chk("R2 truth lookup", lut_q[0], VEC[k][0]);
      chk("R6 bypass", unit_out, VEC[k][0]);
      tick(1);
    end

    // R1: odd table inputs are evt0, per0, pin3
    cfg_truth[15:8] = 8'hAA;
    evt_in = 2'b01; pin_in = 4'b0000; per_in = 1'b0; settle();
    chk("R1 evt0 selected", lut_q[1], 1'b1);
    pin_in = 4'b0111; evt_in = 2'b00; settle();
    chk("R1 unselected pins ignored", lut_q[1], 1'b0);
    evt_in = 2'b10; settle();
    chk("R1 evt1 ignored", lut_q[1], 1'b0);
    cfg_truth[15:8] = 8'hCC; per_in = 1'b1; settle();
    chk("R1 per0 selected", lut_q[1], 1'b1);
    cfg_truth[15:8] = 8'hF0; pin_in = 4'b1000; per_in = 1'b0; settle();
    chk("R1 pin3 selected", lut_q[1], 1'b1);

    // R3: synchronizer
    seq_setup(3'd0);
    cfg_sync = 2'b01;
    pin_in[0] = 1'b1;
    tick(1);
    chk("R3 sync after 1 edge", lut_q[0], 1'b0);
    tick(1);
    chk("R3 sync after 2 edges", lut_q[0], 1'b1);

    // R4: filter
    seq_setup(3'd0);
    cfg_filt = 2'b01;
    pin_in[0] = 1'b1;
    tick(3);
    chk("R4 filter after 3 edges", lut_q[0], 1'b0);
    tick(1);
    chk("R4 filter after 4 edges", lut_q[0], 1'b1);
    pin_in[0] = 1'b0;
    tick(3);
    chk("R4 filter fall after 3", lut_q[0], 1'b1);
    tick(1);
    chk("R4 filter fall after 4", lut_q[0], 1'b0);
    pin_in[0] = 1'b1;
    tick(3);
    pin_in[0] = 1'b0;
    tick(4);
    chk("R4 short pulse blocked", lut_q[0], 1'b0);

    // R5: edge detector
    seq_setup(3'd0);
    cfg_edge = 2'b01;
    pin_in[0] = 1'b1; settle();
    chk("R5 edge pulse high", lut_q[0], 1'b1);
    tick(1);
    chk("R5 edge pulse ends", lut_q[0], 1'b0);
    tick(1);
    chk("R5 edge stays low", lut_q[0], 1'b0);

    // R7: JK
    seq_setup(3'd1);
    pin_in[1:0] = 2'b01; settle();
    chk("R7 JK before edge", unit_out, 1'b0);
    tick(1);
    chk("R7 JK set", unit_out, 1'b1);
    pin_in[1:0] = 2'b11;
    tick(1);
    chk("R7 JK toggle 1", unit_out, 1'b0);
    tick(1);
    chk("R7 JK toggle 2", unit_out, 1'b1);
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R7 JK hold", unit_out, 1'b1);
    pin_in[1:0] = 2'b10;
    tick(1);
    chk("R7 JK clear", unit_out, 1'b0);

    // R8: RS latch
    seq_setup(3'd2);
    pin_in[1:0] = 2'b01; settle();
    chk("R8 RS set immediate", unit_out, 1'b1);
    tick(1);
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R8 RS hold 1", unit_out, 1'b1);
    pin_in[1:0] = 2'b11; settle();
    chk("R8 RS reset priority", unit_out, 1'b0);
    tick(1);
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R8 RS hold 0", unit_out, 1'b0);

    // R9: D latch
    seq_setup(3'd3);
    pin_in[1:0] = 2'b11; settle();
    chk("R9 latch follows 1", unit_out, 1'b1);
    pin_in[1:0] = 2'b10; settle();
    chk("R9 latch follows 0", unit_out, 1'b0);
    pin_in[1:0] = 2'b11;
    tick(1);
    pin_in[1:0] = 2'b01; settle();
    chk("R9 latch closes", unit_out, 1'b1);
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R9 latch holds", unit_out, 1'b1);

    // R10: gated D flip-flop
    seq_setup(3'd4);
    pin_in[1:0] = 2'b11; settle();
    chk("R10 gated before edge", unit_out, 1'b0);
    tick(1);
    chk("R10 gated capture", unit_out, 1'b1);
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R10 gated hold", unit_out, 1'b1);
    pin_in[1:0] = 2'b10;
    tick(1);
    chk("R10 gated capture 0", unit_out, 1'b0);

    // R11: feedback, even table inverts code-7 source
    cfg_sel = sels(3'd7, 3'd2, 3'd2, 3'd1, 3'd2, 3'd2);
    cfg_truth = 16'hAA55;
    cfg_mode = 3'd0;
    pin_in = '0;
    do_reset();
    chk("R11 feedback start", unit_out, 1'b1);
    tick(1);
    chk("R11 feedback toggle 1", unit_out, 1'b0);
    tick(1);
    chk("R11 feedback toggle 2", unit_out, 1'b1);
    tick(1);
    chk("R11 feedback toggle 3", unit_out, 1'b0);

    // R12: reset clears sequential state
    seq_setup(3'd4);
    pin_in[1:0] = 2'b11;
    tick(1);
    rst_n = 1'b0;
    tick(1);
    chk("R12 reset clears state", unit_out, 1'b0);
    rst_n = 1'b1;
    pin_in[1:0] = 2'b00;
    tick(1);
    chk("R12 stays clear", unit_out, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule